// File: doc/BRIEF.md
# Additive Byte-Stream Hash with Prime Reduction

This engine computes a simple additive hash over a stream of key bytes and reduces the sum modulo a prime supplied at run time. A host pulses `start_i` while presenting the key length and the prime. The engine seeds its 32-bit unsigned accumulator with that length. It then accepts exactly that many bytes on a valid/ready stream and adds each byte, zero-extended, to the accumulator.

After the last byte the accumulator is reduced by an iterative restoring remainder unit that needs one cycle per accumulator bit. The remainder is published together with a one-cycle `result_valid_o` strobe. If the prime is zero, no division is done: the raw accumulator is returned and an error flag is raised alongside it. A key length of zero skips the byte phase, so the result comes out without any bytes being consumed.

Top module: `addhash_engine`

## Requirements
- R1: A `start_i` pulse while idle latches `len_i` and `prime_i`, seeds the accumulator with `len_i`, and sets `busy_o` from the next cycle. Later changes on `len_i` and `prime_i` have no effect on that run.
- R2: Each accepted byte (a cycle with `byte_valid_i` and `byte_ready_o` both high) is added, zero-extended, to the 32-bit unsigned accumulator.
- R3: Exactly `len` bytes are accepted. `byte_ready_o` is low once the last one has been taken, and bytes still offered after that change neither the count nor the result.
- R4: With a nonzero prime, `result_o` equals the accumulator modulo the prime, and `err_o` is 0.
- R5: With a prime of 0, `result_o` equals the raw accumulator and `err_o` is 1.
- R6: With a length of 0, no byte is accepted, and the result (0 mod prime, or 0 with `err_o` set) is still produced.
- R7: A `start_i` pulse while busy is ignored; the run in progress completes with its original length and prime.
- R8: `result_valid_o` is high for exactly one cycle per run. `busy_o` is low in that cycle. The strobe comes no more than 40 cycles after the last byte is accepted.
- R9: After reset, `busy_o`, `byte_ready_o`, `result_valid_o`, `err_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| len_i | input | 32 | Key length in bytes; also the accumulator seed |
| prime_i | input | 32 | Modulus for the final reduction |
| byte_valid_i | input | 1 | Key byte present |
| byte_i | input | 8 | Key byte |
| byte_ready_o | output | 1 | Engine accepts a byte this cycle |
| busy_o | output | 1 | A run is in progress |
| result_valid_o | output | 1 | One-cycle strobe: result and error flag updated |
| result_o | output | 32 | Hash after reduction (raw sum when the prime is 0) |
| err_o | output | 1 | The run just finished had a zero prime |

## Verification
A fault in the remaining-byte counter shows at the stream port within one cycle of the last byte: either `byte_ready_o` stays high and takes an extra byte, or it drops early, and the number of accepted bytes no longer matches the length. A fault in the accumulator or the remainder datapath does not show until the strobe, where `result_o` differs from the sum computed by the bench and reduced modulo the prime. That strobe arrives at most about 35 cycles after the last byte. A lost or doubled strobe, or a run that was restarted by a late `start_i`, shows as a wrong pulse width, a timeout, or a result computed from the wrong length.

// File: rtl/addhash_pkg.sv
package addhash_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FEED,
    ST_FINISH,
    ST_REDUCE
  } hash_state_e;
endpackage

// File: rtl/hash_accum.sv
module hash_accum #(
  parameter int ACC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  seed_i,
  input  logic              add_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int PAD_W = ACC_W - BYTE_W;

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= seed_i;
    else if (add_i)  acc_q <= acc_q + {{PAD_W{1'b0}}, byte_i};
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/restoring_mod.sv
module restoring_mod #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W) + 1;

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     rem_q, shf_q;
  logic [W:0]       trial;
  logic             fits;

  // shift the next dividend bit into the partial remainder
  assign trial = {rem_q, shf_q[W-1]};
  assign fits  = trial >= {1'b0, divisor_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      shf_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1;
        cnt_q <= CNT_W'(W);
        rem_q <= '0;
        shf_q <= dividend_i;
      end else if (run_q) begin
        rem_q <= fits ? W'(trial - {1'b0, divisor_i}) : trial[W-1:0];
        shf_q <= shf_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/addhash_engine.sv
module addhash_engine
  import addhash_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ACC_W-1:0]  len_i,
  input  logic [ACC_W-1:0]  prime_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              byte_ready_o,
  output logic              busy_o,
  output logic              result_valid_o,
  output logic [ACC_W-1:0]  result_o,
  output logic              err_o
);
  hash_state_e      state_q;
  logic [ACC_W-1:0] remain_q, prime_q, result_q, acc;
  logic             valid_q, err_q;
  logic             start_ok, accept, div_go, div_done;
  logic [ACC_W-1:0] div_rem;

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign accept   = (state_q == ST_FEED) && byte_valid_i;
  assign div_go   = (state_q == ST_FINISH) && (prime_q != '0);

  hash_accum #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_ok),
    .seed_i (len_i),
    .add_i  (accept),
    .byte_i (byte_i),
    .acc_o  (acc)
  );

  restoring_mod #(.W(ACC_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (div_go),
    .dividend_i (acc),
    .divisor_i  (prime_q),
    .done_o     (div_done),
    .rem_o      (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      prime_q  <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          remain_q <= len_i;
          prime_q  <= prime_i;
          state_q  <= (len_i == '0) ? ST_FINISH : ST_FEED;
        end
        ST_FEED: if (byte_valid_i) begin
          remain_q <= remain_q - 1'b1;
          if (remain_q == ACC_W'(1)) state_q <= ST_FINISH;
        end
        ST_FINISH: begin
          // accumulator settled; zero prime bypasses the divider
          if (prime_q == '0) begin
            result_q <= acc;
            err_q    <= 1'b1;
            valid_q  <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_REDUCE;
          end
        end
        ST_REDUCE: if (div_done) begin
          result_q <= div_rem;
          err_q    <= 1'b0;
          valid_q  <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_ready_o   = (state_q == ST_FEED);
  assign busy_o         = (state_q != ST_IDLE);
  assign result_valid_o = valid_q;
  assign result_o       = result_q;
  assign err_o          = err_q;
endmodule

// File: rtl/addhash_engine_chk.sv
module addhash_engine_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             byte_ready_o,
  input logic             result_valid_o,
  input logic [ACC_W-1:0] result_o,
  input logic             err_o,
  input logic [ACC_W-1:0] prime_q
);
  // R1
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  // R3
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o);

  // R4
  rem_below_prime_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !err_o) |-> (result_o < prime_q));

  // R5
  err_zero_prime_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && err_o) |-> (prime_q == '0));

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(prime_q));

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !busy_o);
endmodule

bind addhash_engine addhash_engine_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .byte_ready_o   (byte_ready_o),
  .result_valid_o (result_valid_o),
  .result_o       (result_o),
  .err_o          (err_o),
  .prime_q        (prime_q)
);

// File: tb/tb_addhash_engine.sv
`timescale 1ns/1ps
module tb_addhash_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] len_i = '0, prime_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        byte_ready_o, busy_o, result_valid_o, err_o;
  logic [31:0] result_o;

  int n_tests = 0, n_fail = 0, taken = 0, cyc = 0;
  logic [7:0] key_mem [64];

  always #2.5 clk_i = ~clk_i;

  addhash_engine dut (
    .clk_i, .rst_ni, .start_i, .len_i, .prime_i, .byte_valid_i, .byte_i,
    .byte_ready_o, .busy_o, .result_valid_o, .result_o, .err_o
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (byte_valid_i && byte_ready_o) taken <= taken + 1;
  end

  always @(posedge clk_i) if (cyc > 150000) begin
    n_fail = n_fail + 1;
    $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [31:0] ref_hash(int n, logic [31:0] p);
    logic [31:0] h = 32'(n);
    for (int i = 0; i < n; i++) h = h + {24'd0, key_mem[i]};
    return (p == 0) ? h : h % p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  // one full run; poke_busy fires a start while the bytes stream in (R7)
  task automatic run_case(int n, logic [31:0] p, bit poke_busy);
    int idx = 0, lat = 0;
    bit seen = 0;
    @(negedge clk_i);
    taken = 0;
    start_i = 1; len_i = 32'(n); prime_i = p;
    @(negedge clk_i);
    start_i = 0; len_i = $urandom; prime_i = $urandom;  // R1: must not matter now
    check("R1 busy after start", 32'(busy_o), 32'd1);
    while (idx < n) begin
      start_i = 0;
      if ($urandom % 4 == 0) byte_valid_i = 0;
      else begin
        byte_valid_i = 1; byte_i = key_mem[idx];
        if (poke_busy && idx == 1) begin
          start_i = 1; len_i = 32'd2; prime_i = 32'd3;
        end
        if (byte_ready_o) idx++;
      end
      @(negedge clk_i);
    end
    start_i = 0;
    byte_valid_i = 1; byte_i = 8'hFF;  // R3: surplus bytes must be refused
    check("R3 ready low after last byte", 32'(byte_ready_o), 32'd0);
    for (int k = 0; k < 60 && !seen; k++) begin
      lat++;
      if (result_valid_o) seen = 1;
      else @(negedge clk_i);
    end
    n_tests++;
    if (!seen || lat > 40) begin
      n_fail++;
      $display("FAIL R8 latency: act=%0d exp<=40 seen=%0d", lat, seen);
    end
    check("R8 idle at strobe", 32'(busy_o), 32'd0);
    check(p == 0 ? "R5 raw sum" : (n == 0 ? "R6 zero length" : "R4 remainder"),
          result_o, ref_hash(n, p));
    check(p == 0 ? "R5 err flag" : "R4 err flag", 32'(err_o), (p == 0) ? 32'd1 : 32'd0);
    check(poke_busy ? "R7 byte count" : (n == 0 ? "R6 no bytes" : "R2 byte count"),
          32'(taken), 32'(n));
    @(negedge clk_i);
    byte_valid_i = 0;
    check("R8 single pulse", 32'(result_valid_o), 32'd0);
    check("R3 count after done", 32'(taken), 32'(n));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) key_mem[i] = 8'($urandom);
    repeat (3) @(negedge clk_i);
    // R9
    check("R9 busy", 32'(busy_o), 32'd0);
    check("R9 ready", 32'(byte_ready_o), 32'd0);
    check("R9 valid", 32'(result_valid_o), 32'd0);
    check("R9 result", result_o, 32'd0);
    check("R9 err", 32'(err_o), 32'd0);
    rst_ni = 1;
    run_case(0, 32'd7, 0);          // R6
    run_case(0, 32'd0, 0);          // R6 + R5
    run_case(5, 32'd0, 0);          // R5
    run_case(8, 32'd1, 0);          // R4 prime 1
    run_case(8, 32'd2, 0);          // R4
    run_case(12, 32'hFFFFFFFB, 0);  // R4 prime above sum
    run_case(1, 32'd13, 0);         // R2 single byte
    run_case(10, 32'd101, 1);       // R7
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < 64; i++) key_mem[i] = 8'($urandom);
      run_case(int'($urandom % 41), ($urandom % 5 == 0) ? 32'd0 : ($urandom % 2 ? 32'(($urandom % 997) + 1) : $urandom | 32'd1), 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule